// File: doc/BRIEF.md
# Multichannel Sample Frame Serializer

This block takes one set of multichannel biosignal samples and sends it over a serial link as a fixed-length byte frame. When the sample strobe pulses while the block is idle, it copies all channel samples and the button inputs into a holding register. It then presents the frame one byte at a time on a valid/ready byte stream that a UART transmitter consumes. The nominal rate is 256 sample sets per second, which leaves the link plenty of time between strobes.

A frame opens with a two-byte sync word. A version byte and a rolling 8-bit frame number follow. Next come the channel samples as low/high byte pairs, and a button byte closes the frame. If a strobe arrives while a frame is still going out, that sample set is discarded, the frame on the wire is left intact, and a sticky overrun flag is raised.

Top module: `biosig_frame_tx`

## Requirements
- R1: After reset, `tx_valid_o` and `overrun_o` are low and the next frame sent carries frame number 0.
- R2: A strobe seen while idle makes `tx_valid_o` high in the following cycle. Exactly 17 bytes are sent, one per valid&ready handshake, and `tx_valid_o` drops in the cycle after the 17th handshake.
- R3: Byte positions 0 and 1 (counting from zero) are 0xA5 and then 0x5A.
- R4: Position 2 is the VERSION parameter (default 2) and position 3 is the frame number.
- R5: Positions 4 to 15 carry channels 0 to 5 in that order. Channel c is taken from `chan_i[16c+15:16c]`, and each channel is sent as its low byte followed by its high byte.
- R6: Position 16 carries `btn_i[3:0]` in bits 3:0, with bits 7:4 sent as zero.
- R7: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds its value.
- R8: The frame number increases by one after each completed frame and wraps from 255 to 0.
- R9: Channel and button values are sampled at the accepted strobe. Input changes after that point do not alter the frame.
- R10: A strobe during a frame, including the cycle of the final handshake, sets `overrun_o`. That sample set is discarded: the frame in progress is unchanged and no extra frame follows. `overrun_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb_i | input | 1 | One-cycle pulse marking a new sample set |
| chan_i | input | 96 | Six 16-bit samples, channel 0 in the low bits |
| btn_i | input | 4 | Button states |
| tx_ready_i | input | 1 | Downstream accepts a byte this cycle |
| tx_data_o | output | 8 | Current frame byte |
| tx_valid_o | output | 1 | `tx_data_o` holds a frame byte |
| overrun_o | output | 1 | Sticky flag: a sample set was discarded |

## Verification
Every output is registered. The first byte appears one cycle after the strobe edge. Each later byte appears one cycle after the handshake edge that consumed the previous byte, and the overrun flag rises one cycle after a strobe that lands during a frame. The bench drives inputs and samples outputs on the falling clock edge. It counts a byte as received only when valid and its own ready are both high at that falling edge, so every comparison falls in the half-cycle after the register update that produced the value. The frame number is checked across more than 256 consecutive frames so that the wrap is observed.

// File: rtl/biosig_frame_pkg.sv
package biosig_frame_pkg;

  localparam logic [7:0] SYNC_HI = 8'hA5;
  localparam logic [7:0] SYNC_LO = 8'h5A;

  // header: two sync bytes, version, frame number; trailer: button byte
  localparam int HDR_BYTES = 4;
  localparam int TRL_BYTES = 1;
  localparam int BYTES_PER_CH = 2;

  typedef enum logic {ST_IDLE, ST_SEND} tx_state_e;

  function automatic int frame_len(input int n_ch);
    return HDR_BYTES + BYTES_PER_CH * n_ch + TRL_BYTES;
  endfunction

endpackage

// File: rtl/sample_latch.sv
module sample_latch #(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 16,
  parameter int NUM_BTN  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] chan_i,
  input  logic [NUM_BTN-1:0]         btn_i,
  output logic [NUM_CH*SAMPLE_W-1:0] chan_q,
  output logic [NUM_BTN-1:0]         btn_q
);

  logic [SAMPLE_W-1:0] snap_r [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)         snap_r[g] <= '0;
      else if (load_i) snap_r[g] <= chan_i[g*SAMPLE_W +: SAMPLE_W];
    end
    assign chan_q[g*SAMPLE_W +: SAMPLE_W] = snap_r[g];
  end

  always_ff @(posedge clk) begin
    if (rst)         btn_q <= '0;
    else if (load_i) btn_q <= btn_i;
  end

  AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(chan_q) && $stable(btn_q))); // R9

endmodule

// File: rtl/frame_byte_sel.sv
module frame_byte_sel
  import biosig_frame_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int SAMPLE_W  = 16,
  parameter int NUM_BTN   = 4,
  parameter int VERSION   = 2,
  parameter int FCNT_W    = 8,
  parameter int FRAME_LEN = 17,
  parameter int IDX_W     = 5
) (
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] chan_i,
  input  logic [NUM_BTN-1:0]         btn_i,
  input  logic [FCNT_W-1:0]          fnum_i,
  output logic [7:0]                 byte_o
);

  localparam int EXT_W = 8 * BYTES_PER_CH;

  logic [7:0] bytes [FRAME_LEN];

  assign bytes[0] = SYNC_HI;
  assign bytes[1] = SYNC_LO;
  assign bytes[2] = 8'(VERSION);
  assign bytes[3] = 8'(fnum_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pair
    logic [EXT_W-1:0] ext;
    assign ext = EXT_W'(chan_i[c*SAMPLE_W +: SAMPLE_W]);
    assign bytes[HDR_BYTES + BYTES_PER_CH*c]     = ext[7:0];
    assign bytes[HDR_BYTES + BYTES_PER_CH*c + 1] = ext[15:8];
  end

  assign bytes[FRAME_LEN-1] = 8'(btn_i);

  always_comb begin
    if (32'(idx_i) < FRAME_LEN) byte_o = bytes[idx_i];
    else                        byte_o = '0;
  end

endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
  import biosig_frame_pkg::*;
#(
  parameter int FRAME_LEN = 17,
  parameter int FCNT_W    = 8,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic              tx_ready_i,
  input  logic [7:0]        next_byte_i,
  output logic              load_o,
  output logic [IDX_W-1:0]  next_idx_o,
  output logic [FCNT_W-1:0] fcnt_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              overrun_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  tx_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             hs;

  assign load_o     = strobe_i && (state == ST_IDLE);
  assign hs         = tx_valid_o && tx_ready_i;
  assign next_idx_o = (state == ST_IDLE) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      fcnt_o     <= '0;
    end else if (state == ST_IDLE) begin
      if (strobe_i) begin
        state      <= ST_SEND;
        idx        <= '0;
        tx_valid_o <= 1'b1;
        tx_data_o  <= next_byte_i;
      end
    end else if (hs) begin
      if (idx == LAST_IDX) begin
        state      <= ST_IDLE;
        tx_valid_o <= 1'b0;
        fcnt_o     <= fcnt_o + 1'b1;
      end else begin
        idx       <= next_idx_o;
        tx_data_o <= next_byte_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             overrun_o <= 1'b0;
    else if (strobe_i && state == ST_SEND) overrun_o <= 1'b1;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(idx) < FRAME_LEN); // R2
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R7
  AST_SYNC_LEAD: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid_o) |-> (tx_data_o == SYNC_HI)); // R3
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o); // R10
  AST_FCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(fcnt_o) |-> (fcnt_o == FCNT_W'($past(fcnt_o) + 1'b1))); // R8

endmodule

// File: rtl/biosig_frame_tx.sv
module biosig_frame_tx
  import biosig_frame_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 16,
  parameter int NUM_BTN  = 4,
  parameter int VERSION  = 2,
  parameter int FCNT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sample_stb_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] chan_i,
  input  logic [NUM_BTN-1:0]         btn_i,
  input  logic                       tx_ready_i,
  output logic [7:0]                 tx_data_o,
  output logic                       tx_valid_o,
  output logic                       overrun_o
);

  localparam int FRAME_LEN = frame_len(NUM_CH);
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);

  logic                       load;
  logic [IDX_W-1:0]           next_idx;
  logic [FCNT_W-1:0]          fcnt;
  logic [7:0]                 next_byte;
  logic [NUM_CH*SAMPLE_W-1:0] chan_snap;
  logic [NUM_BTN-1:0]         btn_snap;

  sample_latch #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NUM_BTN(NUM_BTN)
  ) u_latch (
    .clk(clk), .rst(rst), .load_i(load),
    .chan_i(chan_i), .btn_i(btn_i),
    .chan_q(chan_snap), .btn_q(btn_snap)
  );

  frame_byte_sel #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NUM_BTN(NUM_BTN),
    .VERSION(VERSION), .FCNT_W(FCNT_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)
  ) u_sel (
    .idx_i(next_idx), .chan_i(chan_snap), .btn_i(btn_snap),
    .fnum_i(fcnt), .byte_o(next_byte)
  );

  tx_sequencer #(
    .FRAME_LEN(FRAME_LEN), .FCNT_W(FCNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .strobe_i(sample_stb_i), .tx_ready_i(tx_ready_i),
    .next_byte_i(next_byte), .load_o(load), .next_idx_o(next_idx),
    .fcnt_o(fcnt), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
    .overrun_o(overrun_o)
  );

endmodule

// File: tb/biosig_frame_tx_bench.sv
`timescale 1ns/1ps
module biosig_frame_tx_bench;

  localparam int NB = 17;
  localparam int NV = 5;
  // {channels, buttons, ready pattern}
  localparam logic [101:0] VEC [0:NV-1] = '{
    {96'h0006_0005_0004_0003_0002_0001, 4'h0, 2'd0},
    {96'hFFFF_8000_7FFF_0100_00FF_1234, 4'hF, 2'd1},
    {96'hA5A5_5A5A_DEAD_BEEF_CAFE_0000, 4'h5, 2'd2},
    {96'h0000_0000_0000_0000_0000_0000, 4'hA, 2'd1},
    {96'h1357_9BDF_2468_ACE0_F00F_0FF0, 4'h3, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic [95:0] chan = '0;
  logic [3:0]  btn = '0;
  logic        ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        overrun;

  int         checks = 0;
  int         fails = 0;
  int         exp_fn = 0;
  bit         done = 1'b0;
  logic [7:0] rx [0:NB-1];

  always #2.5 clk = ~clk;

  biosig_frame_tx u_biosig_frame_tx (
    .clk(clk), .rst(rst), .sample_stb_i(stb), .chan_i(chan), .btn_i(btn),
    .tx_ready_i(ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .overrun_o(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stb = 1'b0; ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_fn = 0;
  endtask

  task automatic strobe_with(input logic [95:0] c, input logic [3:0] b);
    @(negedge clk);
    chan = c; btn = b; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    chan = ~c; btn = ~b;   // R9: later input changes must not reach the frame
  endtask

  task automatic get_frame(input int mode);
    int n = 0;
    int t = 0;
    bit r;
    while (n < NB && t < 400) begin
      @(negedge clk);
      t++;
      r = (mode == 0) || (mode == 1 && t % 2 == 0) || (mode == 2 && t % 3 == 0);
      ready = r;
      if (tx_valid && r) begin
        rx[n] = tx_data;
        n++;
      end
    end
    chk(n == NB, "R2 byte count", n, NB);
    @(negedge clk);
    ready = 1'b0;
    chk(!tx_valid, "R2 valid low after last byte", int'(tx_valid), 0);
  endtask

  task automatic check_frame(input logic [95:0] c, input logic [3:0] b, input int fn);
    chk(rx[0] == 8'hA5, "R3 sync byte 0", rx[0], 8'hA5);
    chk(rx[1] == 8'h5A, "R3 sync byte 1", rx[1], 8'h5A);
    chk(rx[2] == 8'd2, "R4 version", rx[2], 2);
    chk(rx[3] == 8'(fn), "R4 frame number", rx[3], fn & 255);
    for (int k = 0; k < 6; k++) begin
      chk(rx[4+2*k] == c[16*k +: 8], "R5 channel low byte", rx[4+2*k], c[16*k +: 8]);
      chk(rx[5+2*k] == c[16*k+8 +: 8], "R5 channel high byte", rx[5+2*k], c[16*k+8 +: 8]);
    end
    chk(rx[16] == {4'h0, b}, "R6 button byte", rx[16], {4'h0, b});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(!tx_valid, "R1 valid after reset", int'(tx_valid), 0);
    chk(!overrun, "R1 overrun after reset", int'(overrun), 0);

    // vector table: R1 first frame number 0, R2..R6, R9 input changes
    for (int v = 0; v < NV; v++) begin
      strobe_with(VEC[v][101:6], VEC[v][5:2]);
      chk(tx_valid && tx_data == 8'hA5, "R2 first byte one cycle after strobe", tx_data, 8'hA5);
      get_frame(int'(VEC[v][1:0]));
      check_frame(VEC[v][101:6], VEC[v][5:2], exp_fn);
      exp_fn++;
    end

    // R8 frame number wrap
    for (int f = 0; f < 260; f++) begin
      strobe_with(96'h0, 4'h0);
      get_frame(0);
      chk(rx[3] == 8'(exp_fn), "R8 frame number sequence", rx[3], exp_fn & 255);
      exp_fn++;
    end

    // R7 stall: data and valid hold while ready low
    strobe_with(VEC[1][101:6], VEC[1][5:2]);
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == 8'hA5, "R7 hold under stall", tx_data, 8'hA5);
    end
    get_frame(0);
    check_frame(VEC[1][101:6], VEC[1][5:2], exp_fn);
    exp_fn++;
    chk(!overrun, "R10 no overrun without collision", int'(overrun), 0);

    // R10 strobe during a frame is discarded
    strobe_with(VEC[2][101:6], VEC[2][5:2]);
    strobe_with(VEC[4][101:6], VEC[4][5:2]);
    chk(overrun, "R10 overrun set", int'(overrun), 1);
    get_frame(1);
    check_frame(VEC[2][101:6], VEC[2][5:2], exp_fn);
    exp_fn++;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      chk(!tx_valid, "R10 no extra frame", int'(tx_valid), 0);
    end
    chk(overrun, "R10 overrun sticky", int'(overrun), 1);

    // R1 reset clears flag and frame number
    do_reset();
    @(negedge clk);
    chk(!overrun && !tx_valid, "R1 reset clears overrun", int'(overrun), 0);
    strobe_with(VEC[0][101:6], VEC[0][5:2]);
    get_frame(0);
    check_frame(VEC[0][101:6], VEC[0][5:2], 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule